// File: doc/BRIEF.md
# Wormhole Crossbar Input-Port Router

This block is the routing logic for one input port of a wormhole-routed crossbar switch with fourteen output channels and 128-bit words. Each frame arriving on the input stream opens with an address word. The router compares that word against a fixed table of channel codes and consumes it without forwarding it. It then opens a path to the matching output channel. Every later word of the frame, including any further address words meant for a cascaded switch downstream, passes through unchanged until the word marked as the frame's close word has been accepted. At that point the path is released and the next word is treated as a new address word.

The address code has its own layout. The word is cut into narrow fields, each five bits wide, and each field repeats the four-bit channel number together with a parity bit. Because of this, a corrupted word does not match any channel. A word that matches no channel, or a close flag on the address word itself, sets a sticky error output. The rest of a bad frame is discarded up to its close word.

The port runs a three-state machine. IDLE waits for an address word. OPEN forwards words to the selected channel. DROP discards the remainder of a badly addressed frame. The transitions are: IDLE→OPEN (a valid code arrives without the close flag), IDLE→DROP (a non-matching word arrives without the close flag), IDLE→IDLE (the address word carries the close flag, or nothing arrives), OPEN→IDLE (the close word is accepted by the selected channel), and DROP→IDLE (the close word arrives).

Top module: `xbar_route_port`

## Requirements
- R1: After reset the machine is in IDLE, `err_flag` is 0, no `out_valid` bit is set and `in_ready` is 1.
- R2: The code for channel c (0..13) fills bits 124:0 with 25 five-bit fields, where field k holds c in bits 5k+3..5k and the XOR of the four bits of c in bit 5k+4; bits 127:125 are zero. The all-zero word therefore selects channel 0.
- R3: In IDLE the address word is accepted (`in_ready`=1) and is never presented on any output.
- R4: While a path is open, each input word appears with its `in_last` flag on `out_data`/`out_last`, and `out_valid` has only the bit of the selected channel set, and only when `in_valid` is 1.
- R5: While a path is open, `in_ready` follows the `out_ready` bit of the selected channel, and the `out_ready` bits of other channels have no effect.
- R6: A word that follows the address word is forwarded as data even when it is itself a valid channel code.
- R7: Once the close word has been accepted on the open path, the machine returns to IDLE, and the next input word is decoded as an address.
- R8: A word in IDLE without the close flag that matches no code sets `err_flag`. The frame is then accepted and discarded up to and including its close word, with no `out_valid` bit set.
- R9: An address word that carries the close flag sets `err_flag`, is consumed and forwards nothing, and the machine stays in IDLE.
- R10: `err_flag` stays at 1 until reset.
- R11: Words in the valid code format with channel value 14 or 15 match no channel and are handled as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 128 | Input word |
| in_last | input | 1 | Input word is the frame's close word |
| out_valid | output | 14 | Per-channel output valid |
| out_ready | input | 14 | Per-channel output ready |
| out_data | output | 128 | Output word, shared by all channels |
| out_last | output | 1 | Output close flag, shared by all channels |
| err_flag | output | 1 | Sticky address error |

## Verification
The assertions assume that the input stream keeps to the valid/ready convention: a word is transferred only in a cycle where both signals are high. They also assume that `in_data` and `in_last` are never unknown while `in_valid` is high. The stimulus drives every input shortly after a rising edge and holds each word until the handshake cycle. It toggles the output ready bits pseudo-randomly, including on channels that are not selected, so that the ready path is exercised without breaking that convention. The reference model decides which cycle transfers a word from the ready value it predicts for itself, never from the one the design reports.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_OPEN = 2'd1,
        PS_DROP = 2'd2
    } port_state_e;

endpackage

// File: rtl/xbar_code_match.sv
module xbar_code_match #(
    parameter int NUM_CH = 14,
    parameter int DATA_W = 128,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [NUM_CH-1:0] match_o,
    output logic              hit_o,
    output logic [CH_W-1:0]   chan_o
);
    localparam int FLD_W  = CH_W + 1;
    localparam int N_FLD  = DATA_W / FLD_W;
    localparam int USED_W = N_FLD * FLD_W;

    // one comparator per channel against its generated code
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam logic [CH_W-1:0] CV = CH_W'(ch);
        logic [DATA_W-1:0] code_w;
        for (genvar f = 0; f < N_FLD; f++) begin : g_fld
            assign code_w[f*FLD_W +: FLD_W] = {^CV, CV};
        end
        if (USED_W < DATA_W) begin : g_pad
            assign code_w[DATA_W-1:USED_W] = '0;
        end
        assign match_o[ch] = (word_i == code_w);
    end

    assign hit_o = |match_o;

    always_comb begin
        chan_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (match_o[i]) chan_o = chan_o | CH_W'(i);
        end
    end
endmodule

// File: rtl/xbar_path_steer.sv
module xbar_path_steer #(
    parameter int NUM_CH = 14,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              open_i,
    input  logic [CH_W-1:0]   sel_i,
    input  logic              valid_i,
    input  logic [NUM_CH-1:0] ready_i,
    output logic [NUM_CH-1:0] valid_o,
    output logic              ready_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        assign valid_o[ch] = open_i && valid_i && (sel_i == CH_W'(ch));
    end

    always_comb begin
        ready_o = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_i == CH_W'(i)) ready_o = ready_i[i];
        end
    end
endmodule

// File: rtl/xbar_route_port.sv
module xbar_route_port
    import xbar_route_pkg::*;
#(
    parameter int NUM_CH = 14,
    parameter int DATA_W = 128,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [NUM_CH-1:0] out_valid,
    input  logic [NUM_CH-1:0] out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              err_flag
);
    port_state_e state_q, state_d;
    logic [CH_W-1:0] sel_q, sel_d;
    logic            err_d;
    logic [NUM_CH-1:0] dec_match;
    logic            dec_hit;
    logic [CH_W-1:0] dec_chan;
    logic            path_ready;
    logic            path_open;

    xbar_code_match #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_match (
        .word_i  (in_data),
        .match_o (dec_match),
        .hit_o   (dec_hit),
        .chan_o  (dec_chan)
    );

    xbar_path_steer #(.NUM_CH(NUM_CH)) u_steer (
        .open_i  (path_open),
        .sel_i   (sel_q),
        .valid_i (in_valid),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .ready_o (path_ready)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            sel_q    <= '0;
            err_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            sel_q    <= sel_d;
            err_flag <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        err_d   = err_flag;
        unique case (state_q)
            PS_IDLE: begin
                if (in_valid) begin
                    if (in_last) begin
                        err_d = 1'b1;
                    end else if (dec_hit) begin
                        sel_d   = dec_chan;
                        state_d = PS_OPEN;
                    end else begin
                        err_d   = 1'b1;
                        state_d = PS_DROP;
                    end
                end
            end
            PS_OPEN: begin
                if (in_valid && path_ready && in_last) state_d = PS_IDLE;
            end
            PS_DROP: begin
                if (in_valid && in_last) state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        path_open = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            PS_IDLE: in_ready = 1'b1;
            PS_OPEN: begin
                path_open = 1'b1;
                in_ready  = path_ready;
            end
            PS_DROP: in_ready = 1'b1;
            default: in_ready = 1'b1;
        endcase
    end

    assign out_data = in_data;
    assign out_last = in_last;

    // R2: distinct codes never match together
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_match));

    // R3, R8, R9: outside an open path nothing is presented
    assert_quiet_when_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_OPEN) |-> (out_valid == '0));

    // R4: at most one channel driven
    assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R5: a channel transfer is an input transfer
    assert_ready_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & out_ready)) |-> in_ready);

    // R7: close word accepted on an open path releases it
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && in_valid && in_ready && in_last) |=> (state_q == PS_IDLE));

    // R9: close flag on the address word keeps the port idle
    assert_close_on_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && in_valid && in_last) |=> (state_q == PS_IDLE && err_flag));

    // R10: the error is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R6: selection holds for the whole open path
    assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && $past(state_q) == PS_OPEN) |-> $stable(sel_q));
endmodule

// File: tb/xbar_route_port_tb_top.sv
`timescale 1ns/1ps
module xbar_route_port_tb_top;
    localparam int NCH = 14;
    localparam int DW  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_data = '0;
    logic in_last = 1'b0;
    logic [NCH-1:0] out_valid;
    logic [NCH-1:0] out_ready = '0;
    logic [DW-1:0] out_data;
    logic out_last;
    logic err_flag;

    int n_tests = 0;
    int n_fail = 0;

    // reference model state
    int m_state = 0;   // 0 idle, 1 open, 2 drop
    int m_sel = 0;
    bit m_err = 1'b0;
    int fwd_cnt = 0;
    logic [DW-1:0] first_fwd;
    int fwd_chan = -1;
    bit rdy_rand = 1'b1;

    always #2.5 clk = ~clk;

    xbar_route_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .err_flag(err_flag)
    );

    function automatic logic [DW-1:0] code_of(int c);
        logic [DW-1:0] w = '0;
        logic [3:0] v = 4'(c);
        for (int k = 0; k < 25; k++) begin
            w[5*k +: 4] = v;
            w[5*k + 4] = v[0] ^ v[1] ^ v[2] ^ v[3];
        end
        return w;
    endfunction

    function automatic int lookup(logic [DW-1:0] w);
        for (int c = 0; c < NCH; c++) if (w == code_of(c)) return c;
        return -1;
    endfunction

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        logic [NCH-1:0] e_valid;
        bit e_ready, hs;
        int d;
        if (!rst_n) begin
            m_state = 0; m_err = 1'b0; m_sel = 0;
        end else begin
            e_ready = (m_state == 1) ? out_ready[m_sel] : 1'b1;
            e_valid = (m_state == 1 && in_valid) ? (NCH'(1) << m_sel) : '0;
            check(out_valid == e_valid, (m_state == 1) ? "R4" : "R3", "out_valid", DW'(out_valid), DW'(e_valid));
            check(in_ready == e_ready, "R5", "in_ready", DW'(in_ready), DW'(e_ready));
            check(err_flag == m_err, "R10", "err_flag", DW'(err_flag), DW'(m_err));
            if (e_valid != '0) begin
                check(out_data == in_data, "R4", "out_data", out_data, in_data);
                check(out_last == in_last, "R4", "out_last", DW'(out_last), DW'(in_last));
            end
            if (|(out_valid & out_ready)) begin
                if (fwd_cnt == 0) first_fwd = out_data;
                fwd_cnt++;
                for (int c = 0; c < NCH; c++) if (out_valid[c]) fwd_chan = c;
            end
            hs = in_valid && e_ready;
            case (m_state)
                0: if (in_valid) begin
                    d = lookup(in_data);
                    if (in_last) m_err = 1'b1;
                    else if (d >= 0) begin m_state = 1; m_sel = d; end
                    else begin m_err = 1'b1; m_state = 2; end
                end
                1: if (hs && in_last) m_state = 0;
                default: if (in_valid && in_last) m_state = 0;
            endcase
        end
    end

    // pseudo-random output backpressure on all channels
    always @(posedge clk) begin
        #1;
        out_ready <= rdy_rand ? NCH'($urandom) : '1;
    end

    task automatic put(logic [DW-1:0] d, bit last);
        bit acc;
        in_valid = 1'b1; in_data = d; in_last = last;
        forever begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #1;
            if (acc) break;
        end
        in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    endtask

    task automatic frame(logic [DW-1:0] addr, int npay, bit cascade, int exp_ch, int exp_fwd, string req);
        fwd_cnt = 0; fwd_chan = -1;
        put(addr, npay == 0);
        for (int i = 0; i < npay; i++) begin
            logic [DW-1:0] w = {$urandom, $urandom, $urandom, $urandom};
            if (i == 0 && cascade) w = code_of(3);
            put(w, i == npay - 1);
        end
        repeat (2) @(posedge clk); #1;
        check(fwd_cnt == exp_fwd, req, "forwarded word count", DW'(fwd_cnt), DW'(exp_fwd));
        if (exp_fwd > 0) check(fwd_chan == exp_ch, req, "channel", DW'(fwd_chan), DW'(exp_ch));
        if (cascade) check(first_fwd == code_of(3), "R6", "second address word", first_fwd, code_of(3));
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        check(in_ready === 1'b1 && out_valid === '0 && err_flag === 1'b0, "R1", "reset state",
              DW'({in_ready, out_valid, err_flag}), DW'({1'b1, 14'd0, 1'b0}));
        rst_n = 1'b1;
        @(posedge clk); #1;
        frame('0, 3, 1'b0, 0, 3, "R2");          // all-zero code selects channel 0
        frame(code_of(5), 4, 1'b0, 5, 4, "R4");
        frame(code_of(13), 2, 1'b0, 13, 2, "R7");
        frame(code_of(9), 1, 1'b0, 9, 1, "R7");  // close on first data word
        frame(code_of(7), 4, 1'b1, 7, 4, "R6");
        rdy_rand = 1'b0;
        frame(code_of(2), 3, 1'b0, 2, 3, "R5");
        rdy_rand = 1'b1;
        check(err_flag == 1'b0, "R8", "no error on good frames", DW'(err_flag), '0);
        frame(code_of(14), 3, 1'b0, 0, 0, "R11");
        check(err_flag == 1'b1, "R11", "error on code 14", DW'(err_flag), DW'(1));
        frame(code_of(15), 2, 1'b0, 0, 0, "R11");
        frame(code_of(4) ^ DW'(1 << 4), 3, 1'b0, 0, 0, "R8"); // parity bit flipped
        frame(code_of(6), 2, 1'b0, 6, 2, "R10");
        check(err_flag == 1'b1, "R10", "error still set", DW'(err_flag), DW'(1));
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(err_flag == 1'b0, "R10", "error cleared by reset", DW'(err_flag), '0);
        frame(code_of(11), 0, 1'b0, 0, 0, "R9");  // close on address word
        check(err_flag == 1'b1, "R9", "error on closed address", DW'(err_flag), DW'(1));
        frame(code_of(12), 2, 1'b0, 12, 2, "R9");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule